// File: doc/BRIEF.md
# Input-Side VOQ Preference Ordering

This block sits at one input port of a crossbar switch that keeps one virtual output queue (VOQ) per output. It tracks how many cells each VOQ holds and, from that, keeps an ordered list of the outputs whose VOQ is occupied. The matcher reads this list as the input's ranking of outputs. Slot 0 is the most preferred output.

The ordering is last-in-first-out at queue level. A VOQ that goes from empty to occupied jumps to slot 0, and every entry already in the list moves back by one slot. More cells into a VOQ that is already occupied leave the ranking alone. When a scheduling-phase transfer drains a VOQ, its entry leaves the list, and the entries behind it move forward by one slot. If a transfer and an arrival occur in the same cycle, the removal is applied first and the insertion second.

Each cycle the block accepts at most one arrival and one transfer. Cell storage and the matching algorithm are handled by other blocks.

Top module: `voq_pref_list`

## Requirements
- R1: After reset, every slot of `pref_vld` reads 0.
- R2: An accepted arrival into an empty VOQ puts that VOQ's index in slot 0 on the next cycle. All entries that were already valid move back by one slot and keep their order.
- R3: An arrival into a VOQ that already holds cells leaves both `pref_idx` and `pref_vld` unchanged.
- R4: A transfer that takes the last cell from a VOQ removes that index from the list. The entries behind it move forward by one slot, and the remaining entries keep their relative order.
- R5: A transfer that leaves at least one cell in its VOQ does not change the list.
- R6: A transfer aimed at an empty VOQ is ignored. It does not change the list, and it does not change any cell count.
- R7: When a transfer and an arrival occur in the same cycle, the removal happens first. This also covers the case where both target the same VOQ and that VOQ holds exactly one cell: the VOQ is then re-inserted at slot 0.
- R8: Valid entries always fill slots 0 to L-1 with no gaps, where L is the number of occupied VOQs. No output index appears more than once among the valid entries.
- R9: Each VOQ count saturates at 2^CNT_W-1. An arrival that would exceed this limit is dropped, unless a transfer from the same VOQ happens in that cycle. A VOQ that is full therefore leaves the list on exactly its 2^CNT_W-1-th transfer.
- R10: The list changes only on the rising clock edge after the event that causes the change. A cycle with no arrival and no transfer leaves the list unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arr_valid | input | 1 | A cell arrives this cycle |
| arr_idx | input | IDX_W | Output (VOQ) index of the arriving cell |
| xfer_valid | input | 1 | A cell leaves a VOQ this cycle (crossbar transfer) |
| xfer_idx | input | IDX_W | Output (VOQ) index of the transferred cell |
| pref_idx | output | N*IDX_W | Ordered list of output indices; slot k occupies bits [k*IDX_W +: IDX_W], and slot 0 is the most preferred |
| pref_vld | output | N | Bit k is set when slot k holds an occupied VOQ |

## Verification
Every effect of an arrival or a transfer shows up on the ports one rising edge after the edge at which the event was sampled. The block has no longer pipeline than that. The bench drives each event on a falling edge, lets exactly one rising edge pass, and compares the whole list at the next falling edge against a queue model it keeps itself. The result is therefore checked in the cycle it is due, neither earlier nor later. Each comparison is tagged with the requirement that the event class exercises: fresh insertion, re-arrival, drain, partial transfer, transfer to an empty VOQ, combined removal and insertion, saturation drop, or an idle cycle.

// File: rtl/voq_pref_list.sv
module voq_pref_list #(
  parameter int N = 4,
  parameter int CNT_W = 3,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arr_valid,
  input  logic [IDX_W-1:0]   arr_idx,
  input  logic               xfer_valid,
  input  logic [IDX_W-1:0]   xfer_idx,
  output logic [N*IDX_W-1:0] pref_idx,
  output logic [N-1:0]       pref_vld
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q [N];
  logic [IDX_W-1:0] ord_q [N];
  logic [IDX_W-1:0] rem_ord [N];
  logic [IDX_W-1:0] nxt_ord [N];
  logic [N-1:0]     vld_q, rem_vld, nxt_vld;
  logic             gone;

  wire arr_in   = arr_valid && (32'(arr_idx) < N);
  wire xfer_in  = xfer_valid && (32'(xfer_idx) < N);
  wire xfer_hit = xfer_in && (cnt_q[xfer_idx] != '0);
  wire drain    = xfer_hit && (cnt_q[xfer_idx] == CNT_W'(1));
  wire same_q   = xfer_hit && (xfer_idx == arr_idx);
  wire arr_acc  = arr_in && ((cnt_q[arr_idx] != CNT_MAX) || same_q);
  wire fill     = arr_in && ((cnt_q[arr_idx] == '0) || (drain && xfer_idx == arr_idx));

  always_comb begin
    for (int k = 0; k < N; k++) begin
      rem_ord[k] = ord_q[k];
      rem_vld[k] = vld_q[k];
    end
    gone = 1'b0;
    for (int k = 0; k < N - 1; k++) begin
      if (drain && vld_q[k] && ord_q[k] == xfer_idx) gone = 1'b1;
      if (gone) begin
        rem_ord[k] = ord_q[k+1];
        rem_vld[k] = vld_q[k+1];
      end
    end
    if (drain && vld_q[N-1] && ord_q[N-1] == xfer_idx) gone = 1'b1;
    if (gone) rem_vld[N-1] = 1'b0;
  end

  always_comb begin
    nxt_ord[0] = fill ? arr_idx : rem_ord[0];
    nxt_vld[0] = fill ? 1'b1 : rem_vld[0];
    for (int k = 1; k < N; k++) begin
      nxt_ord[k] = fill ? rem_ord[k-1] : rem_ord[k];
      nxt_vld[k] = fill ? rem_vld[k-1] : rem_vld[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int k = 0; k < N; k++) begin
        ord_q[k] <= '0;
        cnt_q[k] <= '0;
      end
    end else begin
      vld_q <= nxt_vld;
      for (int k = 0; k < N; k++) begin
        ord_q[k] <= nxt_ord[k];
        if (arr_acc && 32'(arr_idx) == k && !(xfer_hit && 32'(xfer_idx) == k))
          cnt_q[k] <= cnt_q[k] + CNT_W'(1);
        else if (xfer_hit && 32'(xfer_idx) == k && !(arr_acc && 32'(arr_idx) == k))
          cnt_q[k] <= cnt_q[k] - CNT_W'(1);
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign pref_idx[g*IDX_W +: IDX_W] = ord_q[g];
  end
  assign pref_vld = vld_q;
endmodule

// File: rtl/voq_pref_list_chk.sv
module voq_pref_list_chk #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               arr_valid,
  input logic [IDX_W-1:0]   arr_idx,
  input logic               xfer_valid,
  input logic [IDX_W-1:0]   xfer_idx,
  input logic [N*IDX_W-1:0] pref_idx,
  input logic [N-1:0]       pref_vld
);
  logic arr_present, xfer_present, dup;
  logic [IDX_W-1:0] head;

  always_comb begin
    arr_present  = 1'b0;
    xfer_present = 1'b0;
    dup          = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (pref_vld[k] && pref_idx[k*IDX_W +: IDX_W] == arr_idx) arr_present = 1'b1;
      if (pref_vld[k] && pref_idx[k*IDX_W +: IDX_W] == xfer_idx) xfer_present = 1'b1;
      for (int j = k + 1; j < N; j++)
        if (pref_vld[k] && pref_vld[j] &&
            pref_idx[k*IDX_W +: IDX_W] == pref_idx[j*IDX_W +: IDX_W]) dup = 1'b1;
    end
    head = pref_idx[IDX_W-1:0];
  end

  AST_PREFIX_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pref_vld & (pref_vld + 1'b1)) == '0); // R8
  AST_NO_DUPLICATE: assert property (@(posedge clk) disable iff (!rst_n)
    !dup); // R8
  AST_FRESH_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid && (32'(arr_idx) < N) && !arr_present |=> pref_vld[0] && head == $past(arr_idx)); // R2
  AST_REARRIVAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid && arr_present && !xfer_valid |=> $stable(pref_idx) && $stable(pref_vld)); // R3
  AST_EMPTY_XFER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_present && !arr_valid |=> $stable(pref_idx) && $stable(pref_vld)); // R6
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_valid && !xfer_valid |=> $stable(pref_idx) && $stable(pref_vld)); // R10
endmodule

bind voq_pref_list voq_pref_list_chk #(.N(N)) u_chk (.*);

// File: tb/voq_pref_list_bench.sv
`timescale 1ns/1ps
module voq_pref_list_bench;
  localparam int N = 4;
  localparam int CNT_W = 3;
  localparam int IDX_W = $clog2(N);
  localparam int MAXC = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arr_valid = 1'b0, xfer_valid = 1'b0;
  logic [IDX_W-1:0] arr_idx = '0, xfer_idx = '0;
  logic [N*IDX_W-1:0] pref_idx;
  logic [N-1:0] pref_vld;

  int n_chk = 0, n_bad = 0;
  int ref_ord [N];
  int ref_cnt [N];
  int ref_len = 0;

  always #2 clk = ~clk;

  voq_pref_list #(.N(N), .CNT_W(CNT_W)) u_voq_pref_list (
    .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_idx(arr_idx),
    .xfer_valid(xfer_valid), .xfer_idx(xfer_idx),
    .pref_idx(pref_idx), .pref_vld(pref_vld));

  function automatic string model_step(bit av, int ai, bit xv, int xi);
    bit xhit, drained, fresh, acc;
    int pos;
    string tag;
    xhit    = xv && ref_cnt[xi] > 0;
    drained = xhit && ref_cnt[xi] == 1;
    acc     = av && (ref_cnt[ai] < MAXC || (xhit && xi == ai));
    fresh   = av && (ref_cnt[ai] == 0 || (drained && xi == ai));
    if (drained) begin
      pos = 0;
      for (int k = 0; k < ref_len; k++) if (ref_ord[k] == xi) pos = k;
      for (int k = pos; k < ref_len - 1; k++) ref_ord[k] = ref_ord[k+1];
      ref_len--;
    end
    if (fresh) begin
      for (int k = ref_len; k > 0; k--) ref_ord[k] = ref_ord[k-1];
      ref_ord[0] = ai;
      ref_len++;
    end
    if (acc) ref_cnt[ai]++;
    if (xhit) ref_cnt[xi]--;
    if (drained && fresh) tag = "R7";
    else if (drained) tag = "R4";
    else if (fresh) tag = "R2";
    else if (av && !acc) tag = "R9";
    else if (av) tag = "R3";
    else if (xv && !xhit) tag = "R6";
    else if (xv) tag = "R5";
    else tag = "R10";
    return tag;
  endfunction

  task automatic compare(string tag);
    for (int k = 0; k < N; k++) begin
      bit ev;
      int ei;
      ev = k < ref_len;
      ei = ev ? ref_ord[k] : 0;
      n_chk++;
      if (pref_vld[k] !== ev || (ev && int'(pref_idx[k*IDX_W +: IDX_W]) != ei)) begin
        n_bad++;
        $display("FAIL %s slot %0d: actual vld=%0b idx=%0d expected vld=%0b idx=%0d (R8 layout)",
                 tag, k, pref_vld[k], pref_idx[k*IDX_W +: IDX_W], ev, ei);
      end
    end
  endtask

  task automatic drive(bit av, int ai, bit xv, int xi);
    string tag;
    arr_valid = av; arr_idx = ai[IDX_W-1:0];
    xfer_valid = xv; xfer_idx = xi[IDX_W-1:0];
    tag = model_step(av, ai, xv, xi);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) begin ref_ord[k] = 0; ref_cnt[k] = 0; end
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    drive(1, 2, 0, 0);
    drive(1, 0, 0, 0);
    drive(1, 3, 0, 0);
    n_chk++;
    if (pref_vld !== 4'b0111 || pref_idx[5:0] !== {2'd2, 2'd0, 2'd3}) begin
      n_bad++;
      $display("FAIL R2 literal: actual vld=%b idx=%h expected vld=0111 idx=%h",
               pref_vld, pref_idx[5:0], {2'd2, 2'd0, 2'd3});
    end
    drive(1, 0, 0, 0);
    drive(0, 0, 1, 0);
    drive(0, 0, 1, 0);
    drive(0, 0, 1, 1);
    drive(0, 0, 0, 0);
    drive(1, 1, 1, 3);
    drive(1, 2, 1, 2);
    for (int r = 0; r < 9; r++) drive(1, 1, 0, 0);
    for (int r = 0; r < MAXC; r++) drive(0, 0, 1, 1);
    drive(1, 2, 1, 2);
    for (int r = 0; r < 3000; r++) begin
      bit av, xv;
      int ai, xi;
      av = ($urandom % 2) == 0;
      ai = $urandom % N;
      xv = ($urandom % 3) != 0;
      if (ref_len > 0 && ($urandom % 4) != 0) xi = ref_ord[$urandom % ref_len];
      else xi = $urandom % N;
      drive(av, ai, xv, xi);
    end
    drive(0, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule